// File: doc/BRIEF.md
# Dual-Clock Transport Byte FIFO with Gray Pointer Preload

This block carries transport-stream bytes from an input byte clock domain into an internal processing clock domain. The write side accepts one byte on each write clock edge where the valid qualifier is high. Downstream logic pulls bytes on the read clock with a read enable. Both pointers are kept in Gray form. Each pointer crosses into the other domain through a two-flop synchronizer, and full and empty are worked out from those synchronized copies.

Control logic can preset the read pointer with a Gray-coded value. The preset is applied in the read domain on the edge where the load strobe is high. A pulse then crosses into the write domain and forces the write pointer to zero. The distance from the loaded read pointer up to zero becomes the starting fill level, which sets a fixed buffering delay. A sticky alarm reports a write attempted while full or a read attempted while empty. Only the next pointer load clears it.

Top module: `ts_rate_fifo`

## Requirements
- R1: After both resets, empty is 1, full is 0, alarm is 0 and rd_byte is 0x00.
- R2: Bytes written with wr_valid high come out on rd_byte in write order. rd_byte updates on the rd_clk edge where rd_en is high and empty is low.
- R3: A wr_clk edge with wr_valid low stores nothing, whatever is on wr_byte, and leaves the write pointer unchanged.
- R4: full rises once 16 unread bytes are held. A write while full is dropped: the write pointer does not move and the byte is never read out.
- R5: A read while empty leaves rd_byte holding the last byte read and leaves the read pointer unchanged.
- R6: A write while full sets alarm. The event crosses into the read domain, so alarm rises within a few rd_clk cycles.
- R7: A read while empty sets alarm on that same rd_clk edge.
- R8: alarm stays set until a pointer load. It reads 0 after the rd_clk edge that samples ptr_load high.
- R9: ptr_load loads the read pointer with the binary equivalent of the 5-bit Gray value ptr_load_gray and forces the write pointer to 0. After settling, (0 - loaded value) mod 32 bytes can be read. Gray 5'b10010 (binary 28) gives 4 readable entries. Gray 5'b00000 gives none. Bytes written after the load are read in order after those entries.
- R10: Loading Gray 5'b11000 (binary 16) gives a fill of 16. full rises, empty stays low, and a further write sets alarm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Input byte clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_valid | input | 1 | Byte qualifier; a byte is taken on each edge where this is high |
| wr_byte | input | 8 | Incoming byte |
| full | output | 1 | Registered full flag, write domain |
| rd_clk | input | 1 | Processing clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| rd_en | input | 1 | Read request |
| rd_byte | output | 8 | Registered output byte |
| empty | output | 1 | Registered empty flag, read domain |
| ptr_load | input | 1 | One-cycle strobe that presets the read pointer |
| ptr_load_gray | input | 5 | Gray-coded read pointer preset value |
| alarm | output | 1 | Sticky overflow/underflow flag, read domain |

## Verification
A corrupted Gray pointer or a lost load pulse shows up as a wrong fill level. The ports then report the wrong count of readable bytes before empty rises, or a full flag at the wrong count. Both become visible within about a dozen clocks, once the synchronizers settle. A write pointer that moves on a dropped write, or while valid is low, shows up as an extra or out-of-order byte on the next read. A read pointer that moves while empty shows up the same way. A broken alarm path shows as alarm missing a few read cycles after an overflow, or alarm failing to clear on the edge after a load.

// File: rtl/ts_fifo_pkg.sv
package ts_fifo_pkg;
  localparam int TS_DATA_W = 8;
  localparam int TS_ADDR_W = 4;
  localparam int TS_SYNC_N = 2;
endpackage

// File: rtl/ts_fifo_sync.sv
module ts_fifo_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= '0;
          else     stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[i] <= '0;
          else     stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/ts_fifo_ram.sv
module ts_fifo_ram #(
  parameter int DW = 8,
  parameter int AW = 4,
  localparam int DEPTH = 1 << AW
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          rrst,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (rrst)    rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/ts_fifo_wr_ctl.sv
module ts_fifo_wr_ctl #(
  parameter int AW = 4,
  localparam int PW = AW + 1
) (
  input  logic          wr_clk,
  input  logic          wr_rst,
  input  logic          wr_valid,
  input  logic [PW-1:0] rq_gray,
  input  logic          clr_tgl_s,
  output logic          ram_we,
  output logic [AW-1:0] ram_waddr,
  output logic [PW-1:0] w_bin,
  output logic [PW-1:0] w_gray,
  output logic          full,
  output logic          ovf,
  output logic          clr_pulse
);
  logic [PW-1:0] wbin_nx, wgray_nx, full_tgt;
  logic          clr_d, do_wr;

  always_comb begin
    clr_pulse = clr_tgl_s ^ clr_d;
    do_wr     = wr_valid & ~full;
    wbin_nx   = w_bin + PW'(do_wr);
    wgray_nx  = wbin_nx ^ (wbin_nx >> 1);
    full_tgt  = {~rq_gray[PW-1:PW-2], rq_gray[PW-3:0]};
    ram_we    = do_wr & ~clr_pulse;
    ram_waddr = w_bin[AW-1:0];
  end

  always_ff @(posedge wr_clk) begin
    if (wr_rst) begin
      w_bin  <= '0;
      w_gray <= '0;
      full   <= 1'b0;
      ovf    <= 1'b0;
      clr_d  <= 1'b0;
    end else begin
      clr_d <= clr_tgl_s;
      if (clr_pulse) begin
        w_bin  <= '0;
        w_gray <= '0;
        full   <= (full_tgt == '0);
        ovf    <= 1'b0;
      end else begin
        w_bin  <= wbin_nx;
        w_gray <= wgray_nx;
        full   <= (wgray_nx == full_tgt);
        if (wr_valid && full) ovf <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ts_fifo_rd_ctl.sv
module ts_fifo_rd_ctl #(
  parameter int AW = 4,
  localparam int PW = AW + 1
) (
  input  logic          rd_clk,
  input  logic          rd_rst,
  input  logic          rd_en,
  input  logic          load_en,
  input  logic [PW-1:0] load_gray,
  input  logic [PW-1:0] wq_gray,
  input  logic          ovf_s,
  output logic          ram_re,
  output logic [AW-1:0] ram_raddr,
  output logic [PW-1:0] r_bin,
  output logic [PW-1:0] r_gray,
  output logic          empty,
  output logic          alarm,
  output logic          ld_tgl
);
  logic [PW-1:0] rbin_nx, rgray_nx, ld_bin;
  logic          do_rd, ovf_d, ovf_rise;

  always_comb begin
    do_rd      = rd_en & ~empty;
    rbin_nx    = r_bin + PW'(do_rd);
    rgray_nx   = rbin_nx ^ (rbin_nx >> 1);
    ovf_rise   = ovf_s & ~ovf_d;
    ram_re     = do_rd & ~load_en;
    ram_raddr  = r_bin[AW-1:0];
    ld_bin[PW-1] = load_gray[PW-1];
    for (int i = PW - 2; i >= 0; i--) ld_bin[i] = ld_bin[i+1] ^ load_gray[i];
  end

  always_ff @(posedge rd_clk) begin
    if (rd_rst) begin
      r_bin  <= '0;
      r_gray <= '0;
      empty  <= 1'b1;
      alarm  <= 1'b0;
      ld_tgl <= 1'b0;
      ovf_d  <= 1'b0;
    end else begin
      ovf_d <= ovf_s;
      if (load_en) begin
        r_bin  <= ld_bin;
        r_gray <= load_gray;
        empty  <= (load_gray == wq_gray);
        alarm  <= 1'b0;
        ld_tgl <= ~ld_tgl;
      end else begin
        r_bin  <= rbin_nx;
        r_gray <= rgray_nx;
        empty  <= (rgray_nx == wq_gray);
        if ((rd_en && empty) || ovf_rise) alarm <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ts_rate_fifo.sv
module ts_rate_fifo
  import ts_fifo_pkg::*;
#(
  parameter int DATA_W      = TS_DATA_W,
  parameter int ADDR_W      = TS_ADDR_W,
  parameter int SYNC_STAGES = TS_SYNC_N,
  localparam int PTR_W      = ADDR_W + 1
) (
  input  logic              wr_clk,
  input  logic              wr_rst,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_byte,
  output logic              full,
  input  logic              rd_clk,
  input  logic              rd_rst,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_byte,
  output logic              empty,
  input  logic              ptr_load,
  input  logic [PTR_W-1:0]  ptr_load_gray,
  output logic              alarm
);
  logic [PTR_W-1:0]  w_bin, w_gray, r_bin, r_gray, wq_gray, rq_gray;
  logic [ADDR_W-1:0] waddr, raddr;
  logic              we, re, ovf, ovf_s, ld_tgl, clr_tgl_s, clr_pulse;

  ts_fifo_wr_ctl #(.AW(ADDR_W)) wr_ctl_i (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_valid(wr_valid),
    .rq_gray(rq_gray), .clr_tgl_s(clr_tgl_s),
    .ram_we(we), .ram_waddr(waddr), .w_bin(w_bin), .w_gray(w_gray),
    .full(full), .ovf(ovf), .clr_pulse(clr_pulse)
  );

  ts_fifo_rd_ctl #(.AW(ADDR_W)) rd_ctl_i (
    .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en),
    .load_en(ptr_load), .load_gray(ptr_load_gray),
    .wq_gray(wq_gray), .ovf_s(ovf_s),
    .ram_re(re), .ram_raddr(raddr), .r_bin(r_bin), .r_gray(r_gray),
    .empty(empty), .alarm(alarm), .ld_tgl(ld_tgl)
  );

  ts_fifo_ram #(.DW(DATA_W), .AW(ADDR_W)) ram_i (
    .wclk(wr_clk), .we(we), .waddr(waddr), .wdata(wr_byte),
    .rclk(rd_clk), .rrst(rd_rst), .re(re), .raddr(raddr), .rdata(rd_byte)
  );

  ts_fifo_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) w2r_ptr_i (
    .clk(rd_clk), .rst(rd_rst), .d(w_gray), .q(wq_gray));
  ts_fifo_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) r2w_ptr_i (
    .clk(wr_clk), .rst(wr_rst), .d(r_gray), .q(rq_gray));
  ts_fifo_sync #(.W(1), .STAGES(SYNC_STAGES)) w2r_ovf_i (
    .clk(rd_clk), .rst(rd_rst), .d(ovf), .q(ovf_s));
  ts_fifo_sync #(.W(1), .STAGES(SYNC_STAGES)) r2w_clr_i (
    .clk(wr_clk), .rst(wr_rst), .d(ld_tgl), .q(clr_tgl_s));
endmodule

// File: rtl/ts_rate_fifo_chk.sv
module ts_rate_fifo_chk #(
  parameter int DW = 8,
  parameter int PW = 5
) (
  input logic          wr_clk,
  input logic          wr_rst,
  input logic          wr_valid,
  input logic          full,
  input logic          clr_pulse,
  input logic [PW-1:0] w_bin,
  input logic          rd_clk,
  input logic          rd_rst,
  input logic          rd_en,
  input logic          empty,
  input logic          ptr_load,
  input logic [DW-1:0] rd_byte,
  input logic [PW-1:0] r_bin,
  input logic          alarm
);
  a_r3_idle_no_move: assert property (@(posedge wr_clk) disable iff (wr_rst)
    (!wr_valid && !clr_pulse) |=> $stable(w_bin));

  a_r4_no_overflow: assert property (@(posedge wr_clk) disable iff (wr_rst)
    (wr_valid && full && !clr_pulse) |=> $stable(w_bin));

  a_r9_clear_wptr: assert property (@(posedge wr_clk) disable iff (wr_rst)
    clr_pulse |=> (w_bin == '0));

  a_r5_empty_hold_data: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (rd_en && empty && !ptr_load) |=> ($stable(rd_byte) && $stable(r_bin)));

  a_r7_underflow_alarm: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (rd_en && empty && !ptr_load) |=> alarm);

  a_r8_alarm_sticky: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (alarm && !ptr_load) |=> alarm);

  a_r8_load_clears: assert property (@(posedge rd_clk) disable iff (rd_rst)
    ptr_load |=> !alarm);
endmodule

bind ts_rate_fifo ts_rate_fifo_chk #(.DW(DATA_W), .PW(ADDR_W + 1)) chk_i (
  .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_valid(wr_valid), .full(full),
  .clr_pulse(clr_pulse), .w_bin(w_bin),
  .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en), .empty(empty),
  .ptr_load(ptr_load), .rd_byte(rd_byte), .r_bin(r_bin), .alarm(alarm)
);

// File: tb/ts_rate_fifo_tb_top.sv
`timescale 1ns/1ps
module ts_rate_fifo_tb_top;
  logic       wr_clk = 0, rd_clk = 0;
  logic       wr_rst = 1, rd_rst = 1;
  logic       wr_valid = 0, rd_en = 0, ptr_load = 0;
  logic [7:0] wr_byte = 0;
  logic [4:0] ptr_load_gray = 0;
  logic [7:0] rd_byte;
  logic       full, empty, alarm;
  int         checks = 0, errors = 0;
  bit         done = 0;

  always #4   wr_clk = ~wr_clk;
  always #5.5 rd_clk = ~rd_clk;

  ts_rate_fifo dut_i (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_valid(wr_valid), .wr_byte(wr_byte),
    .full(full), .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en),
    .rd_byte(rd_byte), .empty(empty), .ptr_load(ptr_load),
    .ptr_load_gray(ptr_load_gray), .alarm(alarm)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (12) @(negedge rd_clk);
  endtask

  task automatic write_byte(input logic [7:0] d);
    @(negedge wr_clk); wr_valid = 1; wr_byte = d;
    @(negedge wr_clk); wr_valid = 0;
  endtask

  task automatic read_byte(output logic [7:0] d);
    @(negedge rd_clk); rd_en = 1;
    @(negedge rd_clk); rd_en = 0; d = rd_byte;
  endtask

  task automatic load_ptr(input logic [4:0] g);
    @(negedge rd_clk); ptr_load = 1; ptr_load_gray = g;
    @(negedge rd_clk); ptr_load = 0;
    check("R8 alarm cleared by load", alarm, 0);
  endtask

  task automatic t_reset();
    check("R1 empty", empty, 1);
    check("R1 full", full, 0);
    check("R1 alarm", alarm, 0);
    check("R1 rd_byte", rd_byte, 0);
  endtask

  task automatic t_order();
    logic [7:0] d;
    for (int i = 0; i < 5; i++) write_byte(8'hA0 + 8'(i));
    settle();
    check("R2 not empty", empty, 0);
    for (int i = 0; i < 5; i++) begin
      read_byte(d);
      check("R2 order", d, 8'hA0 + i);
    end
    check("R2 empty after drain", empty, 1);
  endtask

  task automatic t_valid_low();
    logic [7:0] d;
    for (int i = 0; i < 10; i++) begin
      @(negedge wr_clk); wr_byte = 8'(8'h10 + i);
    end
    settle();
    check("R3 nothing stored", empty, 1);
    write_byte(8'h5A);
    for (int i = 0; i < 6; i++) begin
      @(negedge wr_clk); wr_byte = 8'(8'hC0 + i);
    end
    settle();
    read_byte(d);
    check("R3 single byte", d, 8'h5A);
    check("R3 no extra byte", empty, 1);
  endtask

  task automatic t_underflow();
    logic [7:0] d;
    check("R7 alarm before", alarm, 0);
    read_byte(d);
    check("R5 data held", d, 8'h5A);
    check("R7 underflow alarm", alarm, 1);
    write_byte(8'h55);
    settle();
    read_byte(d);
    check("R5 pointer unmoved", d, 8'h55);
    check("R8 alarm sticky", alarm, 1);
  endtask

  task automatic t_full();
    logic [7:0] d;
    load_ptr(5'b00000);
    settle();
    check("R9 zero preload empty", empty, 1);
    check("R8 alarm stays clear", alarm, 0);
    for (int i = 0; i < 16; i++) write_byte(8'(i * 3));
    settle();
    check("R4 full at 16", full, 1);
    check("R6 no alarm yet", alarm, 0);
    write_byte(8'hEE);
    settle();
    check("R6 overflow alarm", alarm, 1);
    for (int i = 0; i < 16; i++) begin
      read_byte(d);
      check("R4 stored data", d, i * 3);
    end
    check("R4 dropped byte absent", empty, 1);
    load_ptr(5'b00000);
    settle();
    check("R8 alarm stays clear after load", alarm, 0);
  endtask

  task automatic t_preload();
    logic [7:0] d;
    load_ptr(5'b10010);
    settle();
    check("R9 prefill present", empty, 0);
    for (int i = 0; i < 4; i++) read_byte(d);
    check("R9 four entries", empty, 1);
    for (int i = 0; i < 3; i++) write_byte(8'h31 + 8'(i));
    settle();
    for (int i = 0; i < 3; i++) begin
      read_byte(d);
      check("R9 post-load order", d, 8'h31 + i);
    end
    check("R9 drained", empty, 1);
  endtask

  task automatic t_preload_full();
    logic [7:0] d;
    load_ptr(5'b11000);
    settle();
    check("R10 full", full, 1);
    check("R10 not empty", empty, 0);
    check("R10 alarm clear", alarm, 0);
    write_byte(8'h77);
    settle();
    check("R10 overflow alarm", alarm, 1);
    read_byte(d);
    settle();
    check("R10 full released", full, 0);
  endtask

  initial begin
    repeat (4) @(negedge rd_clk);
    wr_rst = 0; rd_rst = 0;
    repeat (2) @(negedge rd_clk);
    t_reset();
    t_order();
    t_valid_low();
    t_underflow();
    t_full();
    t_preload();
    t_preload_full();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule